// File: doc/BRIEF.md
# Power-Transition Time Stamp Capture

This block keeps two snapshots of the running calendar time, taken whenever the supply source changes between main power and battery backup. One snapshot records the switch from main power to battery. The other records the switch from battery back to main power. Each snapshot holds seconds, minutes, hours, date and month in the same BCD byte format as the live clock. It stores no year and no day of week.

The two snapshots follow opposite retention rules. The main-to-battery snapshot keeps the first switch after a clear and ignores every later one until the host clears it again. The battery-to-main snapshot is rewritten on every switch, so after a series of power cycles it shows the most recent return to main power. A clear, or a reset, sets every byte of both snapshots to 00h. Month 00 is not a valid date, so a value of all zeros means that no event has been recorded since the last clear. Any non-zero value means at least one capture has happened.

The power-source indication is asynchronous. It passes through a synchronizer, and each edge of the synchronized signal captures the time fields. The clear command is a one-cycle strobe from the host register logic.

Top module: `pwr_stamp_top`

## Requirements
- R1: After reset, every byte of `m2b_stamp_o` and `b2m_stamp_o` reads 00h.
- R2: A rise of `on_batt_i` (0 = main, 1 = battery) loads `time_i` into `m2b_stamp_o` with the same field layout: sec [7:0], min [15:8], hour [23:16], date [31:24], month [39:32].
- R3: After a capture, `m2b_stamp_o` ignores any further rises of `on_batt_i` until a clear.
- R4: Every fall of `on_batt_i` loads `time_i` into `b2m_stamp_o`, so it holds the most recent return to main power.
- R5: A one-cycle `clr_i` pulse sets both stamps to all zeros and re-arms the main-to-battery stamp for its next capture.
- R6: When `clr_i` and a capture fall on the same cycle, the clear takes effect first and the capture follows. The stamp then holds the new time, and the main-to-battery stamp is armed-blocked again.
- R7: A change on `on_batt_i` set up between clock edges is captured at the third rising edge after it. This covers two synchronizer stages and one edge register. The `time_i` value taken is the one present at that edge.
- R8: A rise never alters `b2m_stamp_o`, and a fall never alters `m2b_stamp_o`. Once captured, a stamp does not follow later changes on `time_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| on_batt_i | input | 1 | Power source, asynchronous: 1 = battery, 0 = main |
| clr_i | input | 1 | One-cycle clear strobe for both stamps |
| time_i | input | 40 | Live BCD time {month, date, hour, min, sec} |
| m2b_stamp_o | output | 40 | Main-to-battery stamp, first event kept |
| b2m_stamp_o | output | 40 | Battery-to-main stamp, last event kept |

## Verification
The hardest case to reach is a clear strobe landing on exactly the cycle in which a synchronized edge captures the time. The edge only appears internally, two clock edges after the input changes. The bench therefore toggles `on_batt_i` between edges, counts two rising edges, and raises `clr_i` for the single cycle before the third. It does this once for each direction. It then shows that the main-to-battery stamp is blocked again by driving another full power cycle after that capture. The same cycle counting is used to confirm that the stamps are still unchanged one edge before the capture.

// File: rtl/pwr_stamp_pkg.sv
package pwr_stamp_pkg;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned FIELDS  = 5;
  localparam int unsigned STAMP_W = FIELD_W * FIELDS;

  typedef struct packed {
    logic [FIELD_W-1:0] mon;
    logic [FIELD_W-1:0] date;
    logic [FIELD_W-1:0] hour;
    logic [FIELD_W-1:0] min;
    logic [FIELD_W-1:0] sec;
  } stamp_t;
endpackage

// File: rtl/pwr_edge_det.sv
module pwr_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // reset assumes main power
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  a_r7_rise_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  a_r7_fall_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/pwr_stamp_reg.sv
module pwr_stamp_reg
  import pwr_stamp_pkg::*;
#(
  parameter bit KEEP_FIRST = 1'b0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cap_i,
  input  logic   clr_i,
  input  stamp_t time_i,
  output stamp_t stamp_o
);
  stamp_t stamp_q;

  generate
    if (KEEP_FIRST) begin : g_first
      logic held_q;
      logic take;

      // clear first, then capture on the same cycle
      assign take = cap_i & (clr_i | ~held_q);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stamp_q <= '0;
          held_q  <= 1'b0;
        end else if (take) begin
          stamp_q <= time_i;
          held_q  <= 1'b1;
        end else if (clr_i) begin
          stamp_q <= '0;
          held_q  <= 1'b0;
        end
      end

      a_r3_hold_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (held_q && !clr_i) |=> $stable(stamp_o));
      a_r6_clear_then_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_i && clr_i) |=> (stamp_o == $past(time_i)) && held_q);
    end else begin : g_last
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    stamp_q <= '0;
        else if (cap_i) stamp_q <= time_i;
        else if (clr_i) stamp_q <= '0;
      end

      a_r4_take_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_i |=> stamp_o == $past(time_i));
    end
  endgenerate

  assign stamp_o = stamp_q;

  a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !cap_i) |=> stamp_o == '0);
  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !cap_i) |=> $stable(stamp_o));
endmodule

// File: rtl/pwr_stamp_top.sv
module pwr_stamp_top
  import pwr_stamp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               on_batt_i,
  input  logic               clr_i,
  input  logic [STAMP_W-1:0] time_i,
  output logic [STAMP_W-1:0] m2b_stamp_o,
  output logic [STAMP_W-1:0] b2m_stamp_o
);
  logic   to_batt, to_main;
  stamp_t now, m2b, b2m;

  assign now = stamp_t'(time_i);

  pwr_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (on_batt_i),
    .rise_o  (to_batt),
    .fall_o  (to_main)
  );

  pwr_stamp_reg #(.KEEP_FIRST(1'b1)) u_m2b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (to_batt),
    .clr_i   (clr_i),
    .time_i  (now),
    .stamp_o (m2b)
  );

  pwr_stamp_reg #(.KEEP_FIRST(1'b0)) u_b2m (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (to_main),
    .clr_i   (clr_i),
    .time_i  (now),
    .stamp_o (b2m)
  );

  assign m2b_stamp_o = m2b;
  assign b2m_stamp_o = b2m;

  a_r8_one_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({to_batt, to_main}));
  a_r8_rise_keeps_b2m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_batt && !clr_i) |=> $stable(b2m_stamp_o));
  a_r8_fall_keeps_m2b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_main && !clr_i) |=> $stable(m2b_stamp_o));
endmodule

// File: tb/pwr_stamp_top_tb.sv
module pwr_stamp_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        on_batt = 1'b0;
  logic        clr = 1'b0;
  logic [39:0] tm = '0;
  logic [39:0] m2b, b2m;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_stamp_top u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .on_batt_i   (on_batt),
    .clr_i       (clr),
    .time_i      (tm),
    .m2b_stamp_o (m2b),
    .b2m_stamp_o (b2m)
  );

  task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // toggle power source; optional clear on the capture cycle
  task automatic xition(bit to_batt, logic [39:0] t, bit clr_same);
    @(negedge clk);
    tm = t;
    on_batt = to_batt;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (clr_same) clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 m2b", m2b, 40'h0);
    chk("R1 b2m", b2m, 40'h0);
  endtask

  task automatic t_first_and_last();
    xition(1'b1, 40'h01_15_11_30_45, 1'b0);
    chk("R2 m2b capture", m2b, 40'h01_15_11_30_45);
    chk("R8 b2m untouched by rise", b2m, 40'h0);
    xition(1'b0, 40'h02_03_08_05_59, 1'b0);
    chk("R4 b2m capture", b2m, 40'h02_03_08_05_59);
    chk("R8 m2b untouched by fall", m2b, 40'h01_15_11_30_45);
    xition(1'b1, 40'h03_22_23_59_00, 1'b0);
    chk("R3 m2b keeps first", m2b, 40'h01_15_11_30_45);
    xition(1'b0, 40'h12_31_00_00_01, 1'b0);
    chk("R4 b2m keeps last", b2m, 40'h12_31_00_00_01);
  endtask

  task automatic t_clear();
    pulse_clr();
    chk("R5 m2b cleared", m2b, 40'h0);
    chk("R5 b2m cleared", b2m, 40'h0);
    xition(1'b1, 40'h06_10_14_20_33, 1'b0);
    chk("R5 m2b rearmed", m2b, 40'h06_10_14_20_33);
  endtask

  task automatic t_latency();
    @(negedge clk);
    tm = 40'h07_04_09_15_10;
    on_batt = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R7 no capture before third edge", b2m, 40'h0);
    tm = 40'h07_04_09_15_11;
    @(negedge clk);
    chk("R7 time at third edge", b2m, 40'h07_04_09_15_11);
    tm = 40'h09_09_09_09_09;
    repeat (3) @(negedge clk);
    chk("R8 stamp not tracking time_i", b2m, 40'h07_04_09_15_11);
  endtask

  task automatic t_same_cycle();
    // capture flag already set from t_clear; on main power now
    xition(1'b1, 40'h08_18_17_45_30, 1'b1);
    chk("R6 m2b clear then capture", m2b, 40'h08_18_17_45_30);
    chk("R6 b2m cleared by strobe", b2m, 40'h0);
    xition(1'b0, 40'h08_18_18_00_00, 1'b1);
    chk("R6 b2m clear then capture", b2m, 40'h08_18_18_00_00);
    chk("R6 m2b cleared by strobe", m2b, 40'h0);
    xition(1'b1, 40'h10_01_01_01_01, 1'b1);
    xition(1'b0, 40'h10_01_02_02_02, 1'b0);
    xition(1'b1, 40'h10_01_03_03_03, 1'b0);
    chk("R6 m2b blocked after same-cycle capture", m2b, 40'h10_01_01_01_01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_and_last();
    t_clear();
    t_latency();
    t_same_cycle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule